// File: doc/BRIEF.md
# ROM Search Step Sequencer

This block carries out a single branching step of the device-address search on a 1-Wire bus. After a start strobe it asks an external slot engine for two read slots. A read slot is a write-1 slot whose bus level is sampled. The first read returns the address bit of every responding device, and the second returns the complement of that bit. From the two samples and a caller-supplied preferred direction, the block picks which branch of the address tree to follow. It then asks for a third slot that writes the chosen bit, so that devices on the other branch drop out of the search.

When the step ends, the block pulses `done` and holds a 3-bit result on `status`. Bit 0 is the first sample, bit 1 is the second sample and bit 2 is the direction taken. If both samples read 1, no device answered. The block reports this as an error code so that the caller can restart the search, and it writes no direction. Keeping the 64-bit address, remembering the last discrepancy and checking the CRC are left to the logic that drives this block.

Top module: `rom_search_step`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `done`, `status` and `slot_req` are all 0.
- R2: The first two slots requested after a start have `slot_wr_bit` = 1 (read slots). The first returned sample becomes status bit 0 and the second becomes status bit 1.
- R3: The status word is packed as {direction, complement sample, address sample}, with bit 2 holding the direction.
- R4: If both samples are 1, `status` is 3'b011, only two slots are requested, and `done` follows the second slot.
- R5: If both samples are 0, the direction is the `pref_dir` value captured with the start strobe. `status` is 3'b100 for a preference of 1 and 3'b000 for a preference of 0.
- R6: If exactly one sample is 1, the direction equals the first sample. `status` is 3'b101 when that sample is 1 and 3'b010 when it is 0.
- R7: In every non-error case a third slot is requested with `slot_wr_bit` equal to the chosen direction, and `done` rises only after that slot is acknowledged.
- R8: A start strobe, or a change of `pref_dir`, while a step is in progress has no effect on that step's slots or status.
- R9: `done` is high for exactly one cycle per step. `status` holds its value until the next step completes, and `slot_ack` while idle changes nothing.
- R10: `slot_req` is low whenever no step is in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to run a search step |
| pref_dir | input | 1 | Branch to take when both samples are 0; captured with `start` |
| slot_req | output | 1 | A slot is requested; held until `slot_ack` |
| slot_wr_bit | output | 1 | Bit to drive in the requested slot (1 also means read) |
| slot_ack | input | 1 | Slot engine finished the current slot (one cycle) |
| slot_rd_bit | input | 1 | Bus level sampled in the finished slot |
| done | output | 1 | One-cycle pulse when the step result is ready |
| status | output | 3 | {direction, complement sample, address sample} |

## Verification
Several properties are checked on every cycle: the idle request line, the read-slot polarity of the first two slots, the preference locked while busy, the one-cycle done pulse, and the consistency of the error and single-one codes at each completion. The bench scenarios cover what a property cannot see alone. These are the full mapping of every sample pair and preference to a status and a slot count, the direction bit actually driven in the third slot, a start and preference flip partway through a step, and stray acknowledges while idle.

// File: rtl/rom_step_pkg.sv
package rom_step_pkg;
  localparam int STATUS_W = 3;
  localparam int POS_ID   = 0;
  localparam int POS_CMP  = 1;
  localparam int POS_DIR  = 2;
  localparam logic [STATUS_W-1:0] CODE_ERR = 3'b011;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RD_ID,
    S_RD_CMP,
    S_EVAL,
    S_WR_DIR
  } step_state_t;
endpackage

// File: rtl/step_decide.sv
module step_decide
  import rom_step_pkg::*;
(
  input  logic                id_bit,
  input  logic                cmp_bit,
  input  logic                pref,
  output logic                dir,
  output logic                err,
  output logic [STATUS_W-1:0] code
);
  always_comb begin
    err = id_bit & cmp_bit;
    if (id_bit == cmp_bit) dir = pref & ~err;
    else                   dir = id_bit;
    code          = '0;
    code[POS_ID]  = id_bit;
    code[POS_CMP] = cmp_bit;
    code[POS_DIR] = dir;
  end

  always_comb begin
    if (err) a_r4_err_code: assert (code == CODE_ERR);
  end
endmodule

// File: rtl/step_status_reg.sv
module step_status_reg
  import rom_step_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic [STATUS_W-1:0] code,
  output logic                done,
  output logic [STATUS_W-1:0] status
);
  always_ff @(posedge clk) begin
    if (rst) begin
      done   <= 1'b0;
      status <= '0;
    end else begin
      done <= load;
      if (load) status <= code;
    end
  end

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r9_status_hold: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(status) || $past(rst));
  a_r4_err_no_dir: assert property (@(posedge clk) disable iff (rst)
    (done && status[POS_ID] && status[POS_CMP]) |-> !status[POS_DIR]);
  a_r6_single_one: assert property (@(posedge clk) disable iff (rst)
    (done && (status[POS_ID] != status[POS_CMP])) |-> status[POS_DIR] == status[POS_ID]);
endmodule

// File: rtl/step_slot_seq.sv
module step_slot_seq
  import rom_step_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic pref_dir,
  input  logic slot_ack,
  input  logic slot_rd_bit,
  input  logic dir,
  input  logic err,
  output logic slot_req,
  output logic slot_wr_bit,
  output logic id_q,
  output logic cmp_q,
  output logic pref_q,
  output logic load
);
  step_state_t state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= S_IDLE;
      slot_req    <= 1'b0;
      slot_wr_bit <= 1'b1;
      id_q        <= 1'b0;
      cmp_q       <= 1'b0;
      pref_q      <= 1'b0;
      load        <= 1'b0;
    end else begin
      load <= 1'b0;
      unique case (state)
        S_IDLE: if (start) begin
          pref_q      <= pref_dir;
          slot_req    <= 1'b1;
          slot_wr_bit <= 1'b1;
          state       <= S_RD_ID;
        end
        S_RD_ID: if (slot_ack) begin
          id_q  <= slot_rd_bit;
          state <= S_RD_CMP;
        end
        S_RD_CMP: if (slot_ack) begin
          cmp_q    <= slot_rd_bit;
          slot_req <= 1'b0;
          state    <= S_EVAL;
        end
        S_EVAL: begin
          if (err) begin
            load  <= 1'b1;
            state <= S_IDLE;
          end else begin
            slot_req    <= 1'b1;
            slot_wr_bit <= dir;
            state       <= S_WR_DIR;
          end
        end
        S_WR_DIR: if (slot_ack) begin
          slot_req    <= 1'b0;
          slot_wr_bit <= 1'b1;
          load        <= 1'b1;
          state       <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r10_idle_no_req: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE) |-> !slot_req);
  a_r2_read_polarity: assert property (@(posedge clk) disable iff (rst)
    (state == S_RD_ID || state == S_RD_CMP) |-> (slot_req && slot_wr_bit));
  a_r8_pref_locked: assert property (@(posedge clk) disable iff (rst)
    (state != S_IDLE) |=> $stable(pref_q));
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!slot_req && !load));
endmodule

// File: rtl/rom_search_step.sv
module rom_search_step
  import rom_step_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic                pref_dir,
  output logic                slot_req,
  output logic                slot_wr_bit,
  input  logic                slot_ack,
  input  logic                slot_rd_bit,
  output logic                done,
  output logic [STATUS_W-1:0] status
);
  logic id_q, cmp_q, pref_q, load, dir, err;
  logic [STATUS_W-1:0] code;

  step_slot_seq u_seq (
    .clk(clk), .rst(rst), .start(start), .pref_dir(pref_dir),
    .slot_ack(slot_ack), .slot_rd_bit(slot_rd_bit), .dir(dir), .err(err),
    .slot_req(slot_req), .slot_wr_bit(slot_wr_bit),
    .id_q(id_q), .cmp_q(cmp_q), .pref_q(pref_q), .load(load)
  );

  step_decide u_dec (
    .id_bit(id_q), .cmp_bit(cmp_q), .pref(pref_q),
    .dir(dir), .err(err), .code(code)
  );

  step_status_reg u_stat (
    .clk(clk), .rst(rst), .load(load), .code(code),
    .done(done), .status(status)
  );

  a_r1_reset_outputs: assert property (@(posedge clk)
    rst |=> (!done && status == '0));
endmodule

// File: tb/tb_rom_search_step.sv
module tb_rom_search_step;
  logic clk = 1'b0;
  logic rst, start, pref_dir, slot_ack, slot_rd_bit;
  logic slot_req, slot_wr_bit, done;
  logic [2:0] status;
  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  rom_search_step dut (
    .clk(clk), .rst(rst), .start(start), .pref_dir(pref_dir),
    .slot_req(slot_req), .slot_wr_bit(slot_wr_bit),
    .slot_ack(slot_ack), .slot_rd_bit(slot_rd_bit),
    .done(done), .status(status)
  );

  // entry: {pref, id, cmp, exp_status[2:0], exp_slots[1:0], exp_wr_bits[2:0]}
  localparam logic [10:0] VEC [8] = '{
    {3'b000, 3'b000, 2'd3, 3'b011},  // R5 both 0, pref 0
    {3'b100, 3'b100, 2'd3, 3'b111},  // R5 both 0, pref 1
    {3'b001, 3'b010, 2'd3, 3'b011},  // R6 id 0 cmp 1
    {3'b101, 3'b010, 2'd3, 3'b011},  // R6 pref ignored
    {3'b010, 3'b101, 2'd3, 3'b111},  // R6 id 1 cmp 0
    {3'b110, 3'b101, 2'd3, 3'b111},  // R6 pref ignored
    {3'b011, 3'b011, 2'd2, 3'b011},  // R4 both 1
    {3'b111, 3'b011, 2'd2, 3'b011}   // R4 pref ignored
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_step(input logic pref, input logic id, input logic cmp,
                          input int dly, input bit poke,
                          output int n, output logic [2:0] bits,
                          output logic [2:0] st, output bit pulse_ok);
    @(negedge clk);
    start = 1'b1; pref_dir = pref;
    @(negedge clk);
    start = 1'b0;
    n = 0; bits = 3'b000; st = 3'b000;
    while (1) begin
      if (done) begin
        st = status;
        break;
      end
      if (slot_req) begin
        if (n < 3) bits[n] = slot_wr_bit;
        for (int k = 0; k < dly; k++) begin
          if (poke && n == 0 && k == 0) begin
            start = 1'b1; pref_dir = ~pref;
          end
          @(negedge clk);
          start = 1'b0;
        end
        slot_ack = 1'b1;
        slot_rd_bit = (n == 0) ? id : ((n == 1) ? cmp : 1'b1);
        n++;
        @(negedge clk);
        slot_ack = 1'b0;
      end else begin
        @(negedge clk);
      end
    end
    @(negedge clk);
    pulse_ok = !done;
  endtask

  initial begin
    #(8 * 100000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int n;
    logic [2:0] bits, st;
    bit pulse_ok;
    rst = 1'b1; start = 1'b0; pref_dir = 1'b0; slot_ack = 1'b0; slot_rd_bit = 1'b0;
    repeat (3) @(negedge clk);
    check(done == 1'b0, "R1 done in reset", done, 0);
    check(status == 3'b000, "R1 status in reset", status, 0);
    check(slot_req == 1'b0, "R1 slot_req in reset", slot_req, 0);
    rst = 1'b0;
    @(negedge clk);
    check(slot_req == 1'b0 && done == 1'b0, "R10 idle after reset", slot_req, 0);

    for (int i = 0; i < 8; i++) begin
      logic [10:0] v;
      v = VEC[i];
      run_step(v[10], v[9], v[8], 1 + (i % 3), 1'b0, n, bits, st, pulse_ok);
      check(st == v[7:5], "R3/R4/R5/R6 status", st, v[7:5]);
      check(n == int'(v[4:3]), "R4/R7 slot count", n, v[4:3]);
      check(bits[1:0] == 2'b11, "R2 read slots", bits[1:0], 3);
      if (n == 3) check(bits[2] == v[7], "R7 third slot bit", bits[2], v[7]);
      check(pulse_ok, "R9 done single cycle", 0, 1);
    end

    // R8: start and pref flip during a busy step (both samples 0)
    run_step(1'b1, 1'b0, 1'b0, 3, 1'b1, n, bits, st, pulse_ok);
    check(st == 3'b100, "R8 busy start ignored status", st, 4);
    check(n == 3 && bits[2] == 1'b1, "R8 busy start ignored slots", n, 3);
    repeat (3) @(negedge clk);
    check(slot_req == 1'b0, "R8 no extra step launched", slot_req, 0);

    // R9: stray acknowledges while idle
    slot_ack = 1'b1; slot_rd_bit = 1'b1;
    repeat (4) begin
      @(negedge clk);
      check(done == 1'b0 && slot_req == 1'b0, "R9 idle ack no done", done, 0);
    end
    slot_ack = 1'b0;
    check(status == 3'b100, "R9 status held", status, 4);

    // R1: reset mid-step clears outputs
    @(negedge clk); start = 1'b1; pref_dir = 1'b1;
    @(negedge clk); start = 1'b0;
    check(slot_req == 1'b1, "R10 request while busy", slot_req, 1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(slot_req == 1'b0 && status == 3'b000, "R1 reset mid-step", status, 0);
    @(negedge clk);
    check(done == 1'b0, "R1 no done after reset", done, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule